// File: doc/BRIEF.md
# Fractionally Spaced LMS Adaptive Equalizer

This block is a pair of adaptive FIR equalizer rails, one for the in-phase and one for the quadrature component of a received signal. Both rails share timing and configuration. Each rail takes a stream of samples at a fractional rate of two, three or four samples per symbol. At every symbol strobe it forms the dot product of its active coefficients with the most recent samples, and it adapts those coefficients by a least-mean-squares rule. The rule is driven by an error term that the decision stage downstream returns.

The tap span is fixed in symbols (`SPAN_SYM`). The number of active taps therefore follows the selected spacing: two, three or four taps per symbol, out of a bank sized for the densest spacing. The error for a symbol arrives `ERR_LAG` symbols after the output it belongs to. By then `phases × ERR_LAG` newer samples have entered the line. Each coefficient update therefore takes its regressor from a programmable tap further down the sample line, so data, coefficient and error stay aligned at any spacing.

Typical use: present samples with `smp_vld`, one per cycle. Pulse `sym_stb` once per symbol with the error for the symbol `ERR_LAG` strobes earlier. Read `y_i`/`y_q` when `y_vld` is high. Use `freeze` to stop adaptation and `rst` to restart from a single centre tap.

Top module: `lms_fse_eq`

## Requirements
- R1: The in-phase rail uses only `smp_i` and `err_i` and drives `y_i`. The quadrature rail uses only `smp_q` and `err_q` and drives `y_q`. Both share `sp_sel`, `sym_stb`, `freeze`, `step_sh`, `ctr_tap` and `rst`.
- R2: `sp_sel` selects samples per symbol P: 0 gives P=2, 1 gives P=3, and 2 or 3 give P=4. Taps 0 to `SPAN_SYM*P-1` are active and the rest are inactive.
- R3: Each cycle with `smp_vld` high shifts the sample line, with the new sample at position 0. With `smp_vld` low the line keeps its contents whatever `smp_i`/`smp_q` carry.
- R4: A strobe computes y = Σ c[k]·x[k] over the active taps, where x[k] is the line content at position k before any shift in that cycle. The result appears on `y` in the following cycle, with `y_vld` high for exactly that one cycle. At all other times `y` holds its last value.
- R5: On a strobe with `freeze` low, each active coefficient becomes c[k] + ((e·x[k+P·ERR_LAG]) >>> `step_sh`), using an arithmetic shift. The output of the same strobe uses the coefficients from before the update.
- R6: Updated coefficients saturate to the signed `CW`-bit range [-2^(CW-1), 2^(CW-1)-1].
- R7: On a strobe with `freeze` high, every active coefficient keeps its value.
- R8: On every strobe, inactive coefficients are cleared to zero, even under `freeze`. They never contribute to `y`.
- R9: While `rst` is high, all coefficients are cleared except tap `ctr_tap`, which is set to unity 2^(CW-2). The sample line is cleared, `y` is 0 and `y_vld` is low.
- R10: `y` carries the full-precision sum in `DW+CW+log2(4·SPAN_SYM)` signed bits and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads the coefficients |
| sp_sel | input | 2 | Tap spacing select (0: half, 1: third, 2/3: quarter symbol) |
| ctr_tap | input | log2(4·SPAN_SYM) | Tap index loaded with unity during reset |
| smp_vld | input | 1 | Sample strobe at the fractional rate |
| smp_i | input | DW | In-phase sample, signed |
| smp_q | input | DW | Quadrature sample, signed |
| sym_stb | input | 1 | Symbol strobe: compute output and adapt |
| err_i | input | EW | In-phase error, signed |
| err_q | input | EW | Quadrature error, signed |
| step_sh | input | 4 | Step size as a right-shift amount |
| freeze | input | 1 | Hold active coefficients at a strobe |
| y_i | output | YW | In-phase filter output, signed |
| y_q | output | YW | Quadrature filter output, signed |
| y_vld | output | 1 | Output valid, one cycle after a strobe |

## Verification
The coefficients are internal, so saturation, freezing and the clearing of taps that a narrower spacing turns off can only be seen through later filter outputs. The stimulus pins coefficients at the positive and negative limits with extreme samples, full-scale errors and a zero shift. It then freezes them and fills the line with constant samples, so the output is a known sum of saturated terms at the top of the output range. For inactive-tap clearing, the bench adapts at quarter spacing, strobes once at half spacing, and returns to quarter spacing with adaptation frozen. Any leftover weight in the upper taps would then show in the sum.

// File: rtl/lms_eq_pkg.sv
package lms_eq_pkg;

    localparam int MAX_PHASES = 4;
    localparam int STEP_W     = 4;

    typedef enum logic [1:0] {
        SP_HALF        = 2'd0,
        SP_THIRD       = 2'd1,
        SP_QUARTER     = 2'd2,
        SP_QUARTER_ALT = 2'd3
    } spacing_e;

    // Per-symbol control shared by both rails.
    typedef struct packed {
        logic              strobe;
        logic              freeze;
        logic [STEP_W-1:0] step_sh;
    } sym_ctl_t;

    function automatic logic [2:0] phases_of(spacing_e s);
        case (s)
            SP_HALF:  return 3'd2;
            SP_THIRD: return 3'd3;
            default:  return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/lms_spacing_ctl.sv
module lms_spacing_ctl
    import lms_eq_pkg::*;
#(
    parameter  int SPAN_SYM = 16,
    localparam int NTAP     = MAX_PHASES * SPAN_SYM,
    localparam int CNTW     = $clog2(NTAP + 1)
) (
    input  logic [1:0]      sel,
    output logic [2:0]      phases,
    output logic [CNTW-1:0] active_cnt
);

    always_comb begin
        phases     = phases_of(spacing_e'(sel));
        active_cnt = CNTW'(SPAN_SYM) * CNTW'(phases);
    end

endmodule

// File: rtl/lms_rail.sv
module lms_rail
    import lms_eq_pkg::*;
#(
    parameter  int DW       = 8,
    parameter  int CW       = 12,
    parameter  int EW       = 8,
    parameter  int SPAN_SYM = 16,
    parameter  int ERR_LAG  = 1,
    localparam int NTAP     = MAX_PHASES * SPAN_SYM,
    localparam int TW       = $clog2(NTAP),
    localparam int CNTW     = $clog2(NTAP + 1),
    localparam int YW       = DW + CW + TW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   smp_vld,
    input  logic signed [DW-1:0]   smp,
    input  sym_ctl_t               ctl,
    input  logic signed [EW-1:0]   err,
    input  logic [2:0]             phases,
    input  logic [CNTW-1:0]        active_cnt,
    input  logic [TW-1:0]          ctr_tap,
    output logic signed [YW-1:0]   y,
    output logic                   y_vld
);

    localparam int LINE = NTAP + MAX_PHASES * ERR_LAG;
    localparam int PW   = DW + EW;
    localparam int SW   = ((PW > CW) ? PW : CW) + 1;
    localparam logic signed [CW-1:0] UNITY  = CW'(2 ** (CW - 2));
    localparam logic signed [CW-1:0] CMAX   = CW'(2 ** (CW - 1) - 1);
    localparam logic signed [CW-1:0] CMIN   = CW'(-(2 ** (CW - 1)));
    localparam logic signed [SW-1:0] CMAX_W = SW'(2 ** (CW - 1) - 1);
    localparam logic signed [SW-1:0] CMIN_W = SW'(-(2 ** (CW - 1)));

    logic signed [DW-1:0]    line  [LINE];
    logic signed [CW-1:0]    coef  [NTAP];
    logic signed [DW-1:0]    rx    [NTAP];
    logic signed [PW-1:0]    grad  [NTAP];
    logic signed [PW-1:0]    stepd [NTAP];
    logic signed [SW-1:0]    wide  [NTAP];
    logic signed [CW-1:0]    upd   [NTAP];
    logic signed [DW+CW-1:0] prod  [NTAP];
    logic [NTAP-1:0]         tap_on;
    logic signed [YW-1:0]    acc;

    // Sample line at the fractional rate.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINE; i++) line[i] <= '0;
        end else if (smp_vld) begin
            line[0] <= smp;
            for (int i = 1; i < LINE; i++) line[i] <= line[i-1];
        end
    end

    // Regressor selection, gradient, step and saturation per tap.
    always_comb begin
        for (int k = 0; k < NTAP; k++) begin
            tap_on[k] = active_cnt > CNTW'(k);
            case (phases)
                3'd2:    rx[k] = line[k + 2 * ERR_LAG];
                3'd3:    rx[k] = line[k + 3 * ERR_LAG];
                default: rx[k] = line[k + 4 * ERR_LAG];
            endcase
            grad[k]  = err * rx[k];
            stepd[k] = grad[k] >>> ctl.step_sh;
            wide[k]  = SW'(coef[k]) + SW'(stepd[k]);
            if (wide[k] > CMAX_W)      upd[k] = CMAX;
            else if (wide[k] < CMIN_W) upd[k] = CMIN;
            else                       upd[k] = wide[k][CW-1:0];
            prod[k] = coef[k] * line[k];
        end
    end

    // Direct-form sum over the active taps.
    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAP; k++)
            if (tap_on[k]) acc = acc + YW'(prod[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NTAP; k++)
                coef[k] <= (TW'(k) == ctr_tap) ? UNITY : '0;
        end else if (ctl.strobe) begin
            for (int k = 0; k < NTAP; k++) begin
                if (!tap_on[k])      coef[k] <= '0;
                else if (!ctl.freeze) coef[k] <= upd[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y     <= '0;
            y_vld <= 1'b0;
        end else begin
            y_vld <= ctl.strobe;
            if (ctl.strobe) y <= acc;
        end
    end

    // R3: a valid sample lands at the head of the line.
    assert_line_push_R3: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> line[0] == $past(smp));

    // R4: one valid pulse per strobe, output held between strobes.
    assert_vld_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.strobe |=> y_vld);
    assert_vld_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !ctl.strobe |=> !y_vld);
    assert_y_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ctl.strobe |=> $stable(y));

    // R7: tap 0 is active at every spacing, so freeze must hold it.
    assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl.strobe && ctl.freeze) |=> coef[0] == $past(coef[0]));

    // R9: reset leaves the output idle.
    assert_reset_idle_R9: assert property (@(posedge clk)
        rst |=> (!y_vld && y == '0));

    // R8: a strobe clears every tap outside the active window.
    for (genvar g = 0; g < NTAP; g++) begin : g_chk
        assert_inactive_zero_R8: assert property (@(posedge clk) disable iff (rst)
            (ctl.strobe && !tap_on[g]) |=> coef[g] == '0);
    end

endmodule

// File: rtl/lms_fse_eq.sv
module lms_fse_eq
    import lms_eq_pkg::*;
#(
    parameter  int DW       = 8,
    parameter  int CW       = 12,
    parameter  int EW       = 8,
    parameter  int SPAN_SYM = 16,
    parameter  int ERR_LAG  = 1,
    localparam int NTAP     = MAX_PHASES * SPAN_SYM,
    localparam int TW       = $clog2(NTAP),
    localparam int YW       = DW + CW + TW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             sp_sel,
    input  logic [TW-1:0]          ctr_tap,
    input  logic                   smp_vld,
    input  logic signed [DW-1:0]   smp_i,
    input  logic signed [DW-1:0]   smp_q,
    input  logic                   sym_stb,
    input  logic signed [EW-1:0]   err_i,
    input  logic signed [EW-1:0]   err_q,
    input  logic [STEP_W-1:0]      step_sh,
    input  logic                   freeze,
    output logic signed [YW-1:0]   y_i,
    output logic signed [YW-1:0]   y_q,
    output logic                   y_vld
);

    localparam int NRAIL = 2;
    localparam int CNTW  = $clog2(NTAP + 1);

    logic [2:0]            phases;
    logic [CNTW-1:0]       active_cnt;
    sym_ctl_t              ctl;
    logic signed [DW-1:0]  smp_arr [NRAIL];
    logic signed [EW-1:0]  err_arr [NRAIL];
    logic signed [YW-1:0]  y_arr   [NRAIL];
    logic [NRAIL-1:0]      vld_arr;

    assign ctl        = '{strobe: sym_stb, freeze: freeze, step_sh: step_sh};
    assign smp_arr[0] = smp_i;
    assign smp_arr[1] = smp_q;
    assign err_arr[0] = err_i;
    assign err_arr[1] = err_q;
    assign y_i        = y_arr[0];
    assign y_q        = y_arr[1];
    assign y_vld      = &vld_arr;

    lms_spacing_ctl #(.SPAN_SYM(SPAN_SYM)) u_spacing (
        .sel        (sp_sel),
        .phases     (phases),
        .active_cnt (active_cnt)
    );

    for (genvar r = 0; r < NRAIL; r++) begin : g_rail
        lms_rail #(
            .DW(DW), .CW(CW), .EW(EW), .SPAN_SYM(SPAN_SYM), .ERR_LAG(ERR_LAG)
        ) u_rail (
            .clk        (clk),
            .rst        (rst),
            .smp_vld    (smp_vld),
            .smp        (smp_arr[r]),
            .ctl        (ctl),
            .err        (err_arr[r]),
            .phases     (phases),
            .active_cnt (active_cnt),
            .ctr_tap    (ctr_tap),
            .y          (y_arr[r]),
            .y_vld      (vld_arr[r])
        );
    end

endmodule

// File: tb/test_lms_fse_eq.sv
`timescale 1ns/1ps
module test_lms_fse_eq;

    localparam int DW = 8, CW = 12, EW = 8, SPAN = 2, LAG = 1;
    localparam int NTAP = 4 * SPAN;
    localparam int LINE = NTAP + 4 * LAG;
    localparam int TW = 3;
    localparam int YW = DW + CW + TW;
    localparam int CLIM = 2 ** (CW - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] sp_sel = 2'd2;
    logic [TW-1:0] ctr_tap = 3'd3;
    logic smp_vld = 1'b0;
    logic signed [DW-1:0] smp_i = '0, smp_q = '0;
    logic sym_stb = 1'b0;
    logic signed [EW-1:0] err_i = '0, err_q = '0;
    logic [3:0] step_sh = '0;
    logic freeze = 1'b0;
    logic signed [YW-1:0] y_i, y_q;
    logic y_vld;

    int tests = 0, fails = 0;
    int mi [LINE], mq [LINE], ci [NTAP], cq [NTAP];
    int sel_m = 2;
    int last_yi = 0, last_yq = 0;

    always #2 clk = ~clk;

    lms_fse_eq #(.DW(DW), .CW(CW), .EW(EW), .SPAN_SYM(SPAN), .ERR_LAG(LAG)) i_lms_fse_eq (
        .clk(clk), .rst(rst), .sp_sel(sp_sel), .ctr_tap(ctr_tap), .smp_vld(smp_vld),
        .smp_i(smp_i), .smp_q(smp_q), .sym_stb(sym_stb), .err_i(err_i), .err_q(err_q),
        .step_sh(step_sh), .freeze(freeze), .y_i(y_i), .y_q(y_q), .y_vld(y_vld)
    );

    task automatic check(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int phases(int s);
        return (s == 0) ? 2 : (s == 1) ? 3 : 4;
    endfunction

    function automatic int sat(int v);
        if (v > CLIM - 1) return CLIM - 1;
        if (v < -CLIM) return -CLIM;
        return v;
    endfunction

    function automatic int rnd(int lo, int hi);
        return lo + int'($urandom_range(0, hi - lo));
    endfunction

    task automatic set_sel(int s);
        sel_m = s;
        sp_sel = 2'(s);
    endtask

    // R3: one valid sample per call; y_vld must stay low (R4).
    task automatic sample(int a, int b);
        smp_vld = 1'b1; smp_i = DW'(a); smp_q = DW'(b);
        @(negedge clk);
        smp_vld = 1'b0;
        for (int i = LINE - 1; i > 0; i--) begin mi[i] = mi[i-1]; mq[i] = mq[i-1]; end
        mi[0] = a; mq[0] = b;
        check("R4", "y_vld idle", int'(y_vld), 0);
    endtask

    // R4/R5/R6/R7/R8: model of one symbol strobe.
    task automatic strobe(int ei, int eq, int sh, bit frz, string tag);
        int ph, act, d, yi, yq;
        ph = phases(sel_m); act = SPAN * ph; d = ph * LAG;
        yi = 0; yq = 0;
        for (int k = 0; k < act; k++) begin yi += ci[k] * mi[k]; yq += cq[k] * mq[k]; end
        for (int k = 0; k < NTAP; k++) begin
            if (k >= act) begin ci[k] = 0; cq[k] = 0; end
            else if (!frz) begin
                ci[k] = sat(ci[k] + ((ei * mi[k + d]) >>> sh));
                cq[k] = sat(cq[k] + ((eq * mq[k + d]) >>> sh));
            end
        end
        sym_stb = 1'b1; err_i = EW'(ei); err_q = EW'(eq); step_sh = 4'(sh); freeze = frz;
        @(negedge clk);
        sym_stb = 1'b0;
        check(tag, "y_vld", int'(y_vld), 1);
        check(tag, "y_i", int'(y_i), yi);
        check(tag, "y_q", int'(y_q), yq);
        last_yi = yi; last_yq = yq;
    endtask

    task automatic symbol_rand(int sh, bit frz, string tag);
        for (int p = 0; p < phases(sel_m); p++) sample(rnd(-128, 127), rnd(-128, 127));
        strobe(rnd(-128, 127), rnd(-128, 127), sh, frz, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R4: actual >=%0d cycles expected completion", 20000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < LINE; i++) begin mi[i] = 0; mq[i] = 0; end
        for (int k = 0; k < NTAP; k++) begin ci[k] = 0; cq[k] = 0; end
        ci[3] = 2 ** (CW - 2); cq[3] = 2 ** (CW - 2);
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "y_vld in reset", int'(y_vld), 0);
        check("R9", "y_i in reset", int'(y_i), 0);
        check("R9", "y_q in reset", int'(y_q), 0);
        rst = 1'b0;
        @(negedge clk);

        // R9: centre tap at unity, seen through frozen strobes
        for (int n = 0; n < 6; n++) sample(10 * n + 1, -7 * n - 2);
        strobe(0, 0, 0, 1'b1, "R9");
        strobe(100, -100, 0, 1'b1, "R7");

        // R2/R5/R6: sweep spacing and step size with random data
        for (int s = 0; s < 4; s++) begin
            set_sel(s);
            for (int si = 0; si < 4; si++)
                for (int n = 0; n < 5; n++) symbol_rand(3 + 4 * si, 1'b0, "R5");
            for (int n = 0; n < 2; n++) symbol_rand(0, 1'b1, "R2");
        end

        // R7: freeze across several strobes with large errors
        set_sel(2);
        for (int n = 0; n < 4; n++) symbol_rand(0, 1'b1, "R7");

        // R3: changing inputs without smp_vld are ignored; R4 output held
        for (int n = 0; n < 5; n++) begin
            smp_i = DW'(rnd(-128, 127)); smp_q = DW'(rnd(-128, 127));
            @(negedge clk);
            check("R4", "y_i held", int'(y_i), last_yi);
            check("R4", "y_q held", int'(y_q), last_yq);
        end
        strobe(0, 0, 0, 1'b1, "R3");

        // R6/R10: drive I coefs to +max, Q coefs to -min, then full-scale sum
        for (int n = 0; n < LINE; n++) sample(127, -128);
        strobe(127, 127, 0, 1'b0, "R6");
        for (int n = 0; n < LINE; n++) sample(-128, -128);
        strobe(0, 0, 0, 1'b1, "R10");
        strobe(0, 0, 0, 1'b1, "R6");

        // R8: shrink to half spacing, then grow back with adaptation frozen
        for (int n = 0; n < 3; n++) symbol_rand(2, 1'b0, "R5");
        set_sel(0);
        symbol_rand(0, 1'b1, "R8");
        set_sel(3);
        for (int n = 0; n < 4; n++) sample(rnd(-128, 127), rnd(-128, 127));
        strobe(0, 0, 0, 1'b1, "R8");

        // R1: quadrature rail idle while in-phase adapts
        set_sel(1);
        for (int n = 0; n < 6; n++) begin
            for (int p = 0; p < 3; p++) sample(rnd(-128, 127), 0);
            strobe(rnd(-128, 127), 0, 4, 1'b0, "R1");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule